// File: doc/BRIEF.md
# Software-Managed Associative TLB

This block is a fully associative address translation buffer with 64 entries. Software fills it: no hardware walker ever touches a page table. Each entry has two words. The tag word holds a 20-bit virtual page number and a 6-bit address-space identifier. The data word holds a 20-bit physical frame number and four attribute flags: uncached, writable, global and valid. Pages are 4 KiB, so bits [31:12] of a virtual address form the page number.

A combinational lookup port takes a virtual address, the current address-space identifier and a load/store flag. In the same cycle it reports exactly one of four outcomes: hit, miss, invalid-translation fault or write-protection fault. It also returns the frame and the uncached flag of the matched entry.

A management port works on three staging registers: index, tag and data. It runs four operations on them:
- read an entry into the staging registers;
- probe for a match;
- write the entry that the index names;
- write an entry picked by a free-running down-counter.

That counter never selects the lowest eight entries, so software can keep mappings there that random refills will not evict.

Top module: `soft_tlb`

## Requirements
- R1: Reset clears the index, tag and data staging registers to zero and sets the random pointer to 63. Every entry i becomes invalid and non-global, with page number i and ASID 0. After reset, a lookup of page 5 with ASID 0 gives an invalid-translation fault, and the same lookup with ASID 1 gives a miss.
- R2: An entry matches a lookup when its page number equals vaddr[31:12] and, unless it is global, its ASID equals the lookup ASID. In the same cycle, a match on a valid entry that the access is allowed to use raises hit and drives the entry's frame and uncached flag.
- R3: For an entry whose global flag is set, the lookup and the probe ignore the ASID comparison.
- R4: A store that matches a valid entry whose writable flag is clear raises the modify fault and not hit. A load that matches the same entry hits.
- R5: An access that matches an entry whose valid flag is clear raises the invalid-translation fault only, for loads and stores alike.
- R6: Exactly one of hit, miss, invalid-translation fault and modify fault is high at all times. Frame and uncached outputs carry the matched entry's fields, and are zero on a miss.
- R7: Operation code 1 (read) loads the tag and data staging registers, at the next edge, from the entry that index[5:0] selects.
- R8: Operation code 2 (probe) compares the tag staging register with every entry, whatever the entries' valid flags. On a match it loads index with the entry number and bit 6 clear.
- R9: A probe that finds no match loads index with 7'h40 (bit 6 set, low bits zero).
- R10: Operation code 3 writes the tag and data staging registers into the entry that index[5:0] selects. The staging registers use this packing: tag = {vpn[19:0], asid[5:0]} and data = {pfn[19:0], uncached, writable, global, valid}, with valid in bit 0.
- R11: Operation code 4 writes the tag and data staging registers into the entry named by the random pointer's value in that cycle. That value is always 8 or more.
- R12: The random pointer decrements once per clock from 63 to 8, then returns to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_vaddr_i | input | 32 | Lookup virtual address |
| lk_asid_i | input | 6 | Lookup address-space identifier |
| lk_store_i | input | 1 | Lookup is a store (1) or a load (0) |
| lk_hit_o | output | 1 | Usable translation found |
| lk_pfn_o | output | 20 | Frame number of the matched entry |
| lk_nocache_o | output | 1 | Uncached flag of the matched entry |
| lk_miss_o | output | 1 | No entry matched |
| lk_inval_o | output | 1 | Matched entry is invalid |
| lk_mod_o | output | 1 | Store to a non-writable entry |
| op_i | input | 3 | 0 none, 1 read, 2 probe, 3 indexed write, 4 random write |
| idx_we_i | input | 1 | Load the index staging register |
| idx_wdata_i | input | 6 | Index value to load |
| hi_we_i | input | 1 | Load the tag staging register |
| hi_wdata_i | input | 26 | Tag value {vpn, asid} |
| lo_we_i | input | 1 | Load the data staging register |
| lo_wdata_i | input | 24 | Data value {pfn, uncached, writable, global, valid} |
| idx_o | output | 7 | Index staging register, bit 6 is the probe-failure flag |
| hi_o | output | 26 | Tag staging register |
| lo_o | output | 24 | Data staging register |
| rand_o | output | 6 | Current random pointer |

## Verification
The assertions rely on three things about the inputs:
- no lookup or probe ever matches two entries at once;
- op_i only takes the codes 0 to 4;
- no staging-register write strobe shares a cycle with an operation that loads the same register.

The stimulus keeps within these limits. Installed pages sit at 0x400 and above, away from the reset pages 0 to 63. The random-write page appears nowhere else. Register loads and operations are always issued in separate cycles.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int VA_W    = 32;
  localparam int PAGE_W  = 12;
  localparam int VPN_W   = VA_W - PAGE_W;
  localparam int ASID_W  = 6;
  localparam int PFN_W   = 20;
  localparam int ENTRIES = 64;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int RAND_LO = 8;
  localparam int HI_W    = VPN_W + ASID_W;
  localparam int LO_W    = PFN_W + 4;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
  } hi_t;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             nc;
    logic             wr;
    logic             glb;
    logic             vld;
  } lo_t;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_READ   = 3'd1,
    OP_PROBE  = 3'd2,
    OP_WR_IDX = 3'd3,
    OP_WR_RND = 3'd4
  } op_e;
endpackage

// File: rtl/tlb_rand_ptr.sv
`timescale 1ns/1ps
module tlb_rand_ptr #(
  parameter int N  = 64,
  parameter int LO = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [IW-1:0] ptr_o
);
  localparam logic [IW-1:0] TOP = IW'(N - 1);
  localparam logic [IW-1:0] BOT = IW'(LO);

  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= TOP;
    else if (ptr_q == BOT) ptr_q <= TOP;
    else                  ptr_q <= ptr_q - 1'b1;
  end

  assign ptr_o = ptr_q;

  AST_RAND_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o >= BOT); // R12
  AST_RAND_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o == BOT |=> ptr_o == TOP); // R12
  AST_RAND_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o != BOT |=> ptr_o == $past(ptr_o) - 1'b1); // R12
endmodule

// File: rtl/tlb_enc.sv
`timescale 1ns/1ps
module tlb_enc #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  oh_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      if (oh_i[k]) idx_o = idx_o | IW'(k);
    end
  end

  assign any_o = |oh_i;
endmodule

// File: rtl/tlb_cam.sv
`timescale 1ns/1ps
module tlb_cam import tlb_pkg::*; #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     widx_i,
  input  hi_t               whi_i,
  input  lo_t               wlo_i,
  input  logic [IW-1:0]     ridx_i,
  output hi_t               rhi_o,
  output lo_t               rlo_o,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic [N-1:0]      lk_match_o,
  output lo_t               lk_lo_o,
  input  hi_t               pr_hi_i,
  output logic [N-1:0]      pr_match_o
);
  hi_t hi_a [N];
  lo_t lo_a [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    hi_t hi_q;
    lo_t lo_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= '{vpn: VPN_W'(i), asid: '0};
        lo_q <= '0;
      end else if (we_i && widx_i == IW'(i)) begin
        hi_q <= whi_i;
        lo_q <= wlo_i;
      end
    end

    assign hi_a[i] = hi_q;
    assign lo_a[i] = lo_q;
    assign lk_match_o[i] = (hi_q.vpn == lk_vpn_i) &&
                           (lo_q.glb || hi_q.asid == lk_asid_i);
    assign pr_match_o[i] = (hi_q.vpn == pr_hi_i.vpn) &&
                           (lo_q.glb || hi_q.asid == pr_hi_i.asid);
  end

  assign rhi_o = hi_a[ridx_i];
  assign rlo_o = lo_a[ridx_i];

  // and-or select; a miss yields all zero
  always_comb begin
    lk_lo_o = '0;
    for (int k = 0; k < N; k++) begin
      if (lk_match_o[k]) lk_lo_o = lk_lo_o | lo_a[k];
    end
  end
endmodule

// File: rtl/soft_tlb.sv
`timescale 1ns/1ps
module soft_tlb import tlb_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_store_i,
  output logic              lk_hit_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  output logic              lk_nocache_o,
  output logic              lk_miss_o,
  output logic              lk_inval_o,
  output logic              lk_mod_o,
  input  logic [2:0]        op_i,
  input  logic              idx_we_i,
  input  logic [IDX_W-1:0]  idx_wdata_i,
  input  logic              hi_we_i,
  input  logic [HI_W-1:0]   hi_wdata_i,
  input  logic              lo_we_i,
  input  logic [LO_W-1:0]   lo_wdata_i,
  output logic [IDX_W:0]    idx_o,
  output logic [HI_W-1:0]   hi_o,
  output logic [LO_W-1:0]   lo_o,
  output logic [IDX_W-1:0]  rand_o
);
  op_e                op;
  logic [IDX_W:0]     idx_q;
  hi_t                hi_q;
  lo_t                lo_q;
  logic [IDX_W-1:0]   rnd;
  logic               cam_we;
  logic [IDX_W-1:0]   cam_widx;
  hi_t                rd_hi;
  lo_t                rd_lo;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] pr_match;
  lo_t                lk_lo;
  logic [IDX_W-1:0]   pr_idx;
  logic               pr_any;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx_unused;

  assign op = op_e'(op_i);

  tlb_rand_ptr #(.N(ENTRIES), .LO(RAND_LO)) u_rand (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ptr_o (rnd)
  );

  assign cam_we   = (op == OP_WR_IDX) || (op == OP_WR_RND);
  assign cam_widx = (op == OP_WR_RND) ? rnd : idx_q[IDX_W-1:0];

  tlb_cam #(.N(ENTRIES)) u_cam (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cam_we),
    .widx_i    (cam_widx),
    .whi_i     (hi_q),
    .wlo_i     (lo_q),
    .ridx_i    (idx_q[IDX_W-1:0]),
    .rhi_o     (rd_hi),
    .rlo_o     (rd_lo),
    .lk_vpn_i  (lk_vaddr_i[VA_W-1:PAGE_W]),
    .lk_asid_i (lk_asid_i),
    .lk_match_o(lk_match),
    .lk_lo_o   (lk_lo),
    .pr_hi_i   (hi_q),
    .pr_match_o(pr_match)
  );

  tlb_enc #(.N(ENTRIES)) u_pr_enc (
    .oh_i (pr_match),
    .idx_o(pr_idx),
    .any_o(pr_any)
  );

  tlb_enc #(.N(ENTRIES)) u_lk_enc (
    .oh_i (lk_match),
    .idx_o(lk_idx_unused),
    .any_o(lk_any)
  );

  // staging registers; an operation result overrides a direct load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      if (idx_we_i) idx_q <= {1'b0, idx_wdata_i};
      if (hi_we_i)  hi_q  <= hi_t'(hi_wdata_i);
      if (lo_we_i)  lo_q  <= lo_t'(lo_wdata_i);
      case (op)
        OP_READ: begin
          hi_q <= rd_hi;
          lo_q <= rd_lo;
        end
        OP_PROBE: idx_q <= {~pr_any, pr_any ? pr_idx : '0};
        default: ;
      endcase
    end
  end

  assign lk_miss_o    = !lk_any;
  assign lk_inval_o   = lk_any && !lk_lo.vld;
  assign lk_mod_o     = lk_any && lk_lo.vld && lk_store_i && !lk_lo.wr;
  assign lk_hit_o     = lk_any && lk_lo.vld && !(lk_store_i && !lk_lo.wr);
  assign lk_pfn_o     = lk_lo.pfn;
  assign lk_nocache_o = lk_lo.nc;

  assign idx_o  = idx_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign rand_o = rnd;

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({lk_hit_o, lk_miss_o, lk_inval_o, lk_mod_o}) == 1); // R6
  AST_MOD_ONLY_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_mod_o |-> lk_store_i); // R4
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_miss_o |-> (lk_pfn_o == '0 && !lk_nocache_o)); // R6
  AST_READ_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_READ |=> (hi_o == $past(rd_hi) && lo_o == $past(rd_lo))); // R7
  AST_PROBE_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_PROBE && pr_match == '0) |=> idx_o == {1'b1, {IDX_W{1'b0}}}); // R9
  AST_PROBE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_PROBE && $onehot(pr_match)) |=> !idx_o[IDX_W]); // R8
  AST_RND_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_WR_RND |-> cam_widx >= IDX_W'(RAND_LO)); // R11
endmodule

// File: tb/soft_tlb_test.sv
`timescale 1ns/1ps
module soft_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [5:0]  lk_asid = '0;
  logic        lk_store = 1'b0;
  logic        lk_hit, lk_nocache, lk_miss, lk_inval, lk_mod;
  logic [19:0] lk_pfn;
  logic [2:0]  op = '0;
  logic        idx_we = 1'b0, hi_we = 1'b0, lo_we = 1'b0;
  logic [5:0]  idx_wdata = '0;
  logic [25:0] hi_wdata = '0;
  logic [23:0] lo_wdata = '0;
  logic [6:0]  idx_out;
  logic [25:0] hi_out;
  logic [23:0] lo_out;
  logic [5:0]  rnd;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  soft_tlb uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_vaddr_i(lk_vaddr), .lk_asid_i(lk_asid), .lk_store_i(lk_store),
    .lk_hit_o(lk_hit), .lk_pfn_o(lk_pfn), .lk_nocache_o(lk_nocache),
    .lk_miss_o(lk_miss), .lk_inval_o(lk_inval), .lk_mod_o(lk_mod),
    .op_i(op), .idx_we_i(idx_we), .idx_wdata_i(idx_wdata),
    .hi_we_i(hi_we), .hi_wdata_i(hi_wdata), .lo_we_i(lo_we), .lo_wdata_i(lo_wdata),
    .idx_o(idx_out), .hi_o(hi_out), .lo_o(lo_out), .rand_o(rnd)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [5:0]  asid;
    logic        st;
    logic [3:0]  res;  // {hit, miss, inval, mod}
    logic        nc;
    logic [19:0] pfn;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{32'h0040_0123, 6'd5,  1'b0, 4'b1000, 1'b0, 20'h0A000, 4'd2},
    '{32'h0040_0FFF, 6'd5,  1'b1, 4'b1000, 1'b0, 20'h0A000, 4'd2},
    '{32'h0040_0000, 6'd6,  1'b0, 4'b0100, 1'b0, 20'h00000, 4'd6},
    '{32'h0040_1010, 6'd5,  1'b0, 4'b1000, 1'b0, 20'h0A001, 4'd4},
    '{32'h0040_1010, 6'd5,  1'b1, 4'b0001, 1'b0, 20'h0A001, 4'd4},
    '{32'h0040_2000, 6'd33, 1'b0, 4'b1000, 1'b1, 20'h0A002, 4'd3},
    '{32'h0040_2ABC, 6'd0,  1'b1, 4'b1000, 1'b1, 20'h0A002, 4'd3},
    '{32'h0040_3000, 6'd5,  1'b0, 4'b0010, 1'b0, 20'h0A003, 4'd5},
    '{32'h0040_3000, 6'd5,  1'b1, 4'b0010, 1'b0, 20'h0A003, 4'd5},
    '{32'h0040_4000, 6'd5,  1'b0, 4'b0100, 1'b0, 20'h00000, 4'd6},
    '{32'h0000_5000, 6'd0,  1'b0, 4'b0010, 1'b0, 20'h00000, 4'd1},
    '{32'h0000_5000, 6'd1,  1'b0, 4'b0100, 1'b0, 20'h00000, 4'd1},
    '{32'h0040_1000, 6'd4,  1'b1, 4'b0100, 1'b0, 20'h00000, 4'd6}
  };

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_op(input logic [2:0] c);
    op = c;
    tick();
    op = 3'd0;
  endtask

  task automatic stage(input logic [5:0] i, input logic [19:0] vpn, input logic [5:0] asid,
                       input logic [23:0] lo);
    idx_we = 1'b1; idx_wdata = i;
    hi_we = 1'b1;  hi_wdata = {vpn, asid};
    lo_we = 1'b1;  lo_wdata = lo;
    tick();
    idx_we = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
  endtask

  task automatic set_idx(input logic [5:0] i);
    idx_we = 1'b1; idx_wdata = i;
    tick();
    idx_we = 1'b0;
  endtask

  task automatic set_hi(input logic [19:0] vpn, input logic [5:0] asid);
    hi_we = 1'b1; hi_wdata = {vpn, asid};
    tick();
    hi_we = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic st);
    lk_vaddr = va; lk_asid = asid; lk_store = st;
    #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] r;
    logic [5:0] exp_r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {57'd0, idx_out}, 64'd0);
    chk("R1", {38'd0, hi_out}, 64'd0);
    chk("R1", {40'd0, lo_out}, 64'd0);
    chk("R1", {58'd0, rnd}, 64'd63);
    rst_n = 1'b1;
    @(negedge clk);

    stage(6'd0, 20'h00400, 6'd5, {20'h0A000, 4'b0101});
    do_op(3'd3);
    stage(6'd1, 20'h00401, 6'd5, {20'h0A001, 4'b0001});
    do_op(3'd3);
    stage(6'd2, 20'h00402, 6'd0, {20'h0A002, 4'b1111});
    do_op(3'd3);
    stage(6'd3, 20'h00403, 6'd5, {20'h0A003, 4'b0100});
    do_op(3'd3);

    for (int v = 0; v < NV; v++) begin
      look(VEC[v].va, VEC[v].asid, VEC[v].st);
      chk(req_name(VEC[v].req), {59'd0, lk_hit, lk_miss, lk_inval, lk_mod, lk_nocache},
          {59'd0, VEC[v].res, VEC[v].nc});
      chk(req_name(VEC[v].req), {44'd0, lk_pfn}, {44'd0, VEC[v].pfn});
      @(negedge clk);
    end

    // R7 read entry 2
    set_idx(6'd2);
    do_op(3'd1);
    chk("R7", {38'd0, hi_out}, {38'd0, 20'h00402, 6'd0});
    chk("R7", {40'd0, lo_out}, {40'd0, 20'h0A002, 4'b1111});

    // R8 probe hits, including an invalid entry
    set_hi(20'h00401, 6'd5);
    do_op(3'd2);
    chk("R8", {57'd0, idx_out}, 64'd1);
    set_hi(20'h00403, 6'd5);
    do_op(3'd2);
    chk("R8", {57'd0, idx_out}, 64'd3);
    // R3 global entry probed with another ASID
    set_hi(20'h00402, 6'd17);
    do_op(3'd2);
    chk("R3", {57'd0, idx_out}, 64'd2);
    // R9 probe miss
    set_hi(20'h00777, 6'd5);
    do_op(3'd2);
    chk("R9", {57'd0, idx_out}, 64'h40);

    // R10 overwrite entry 1 as writable
    stage(6'd1, 20'h00401, 6'd5, {20'h0B001, 4'b0101});
    do_op(3'd3);
    look(32'h0040_1010, 6'd5, 1'b1);
    chk("R10", {58'd0, lk_hit, lk_mod, lk_pfn[3:0]}, {58'd0, 2'b10, 4'h1});
    chk("R10", {44'd0, lk_pfn}, {44'd0, 20'h0B001});

    // R11 random write
    stage(6'd0, 20'h00500, 6'd7, {20'h0B500, 4'b0101});
    r = rnd;
    do_op(3'd4);
    chk("R11", {63'd0, (r >= 6'd8)}, 64'd1);
    look(32'h0050_0000, 6'd7, 1'b0);
    chk("R11", {43'd0, lk_hit, lk_pfn}, {43'd0, 1'b1, 20'h0B500});
    set_idx(r);
    hi_we = 1'b1; hi_wdata = '0;
    tick();
    hi_we = 1'b0;
    do_op(3'd1);
    chk("R11", {38'd0, hi_out}, {38'd0, 20'h00500, 6'd7});

    // R12 pointer sequence
    exp_r = rnd;
    for (int c = 0; c < 120; c++) begin
      tick();
      exp_r = (exp_r == 6'd8) ? 6'd63 : exp_r - 6'd1;
      chk("R12", {58'd0, rnd}, {58'd0, exp_r});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule